// File: doc/BRIEF.md
# SPI Master Preload-Then-Loopback Sequencer

This block exercises an external command-driven SPI master by writing its registers. After reset it programs the master's clock-rate register once. From then on it is paced by an internal periodic tick. On a tick, if the master's command register reads zero (meaning the master is idle), the sequencer starts one transfer. While it is in the preload phase, a transfer means writing the two halves of a fixed 16-bit word into the master's shift buffer and then writing the command byte.

After a parameterised number of such transfers the sequencer switches to loopback for good. In loopback it writes only the command byte. The master's buffer then still holds whatever it shifted in last time, so each received word is sent straight back out. The tick period (in system clocks), the preload count, the data word, the command byte and the rate byte are all parameters.

Register writes leave the block on a valid/ready port. A beat is taken on any clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay frozen. A beat that has been offered is never withdrawn. Register selector codes on `wr_addr`: 0 = command, 1 = buffer high byte, 2 = buffer low byte, 3 = clock rate.

Top module: `spi_loopback_seq`

## Requirements
- R1: While reset is asserted, `wr_valid` is 0, `loop_phase` is 0 and `xfer_count` is 0.
- R2: The first beat after reset writes selector 3 with `RATE_BYTE`, without waiting for a tick.
- R3: While `wr_valid` is high and `wr_ready` is low, the next cycle still has `wr_valid` high with `wr_addr` and `wr_data` unchanged.
- R4: A transfer (any beat other than the rate write) begins only in the cycle after a tick in which `mst_cmd_q` read zero. A tick that finds `mst_cmd_q` nonzero, or that arrives while a transfer is in progress, is dropped.
- R5: A preload transfer is exactly three beats in this order: selector 1 with `DATA_WORD[15:8]`, selector 2 with `DATA_WORD[7:0]`, then selector 0 with `CMD_BYTE`.
- R6: Exactly `INIT_XFERS` preload transfers are made. `loop_phase` goes to 1 in the cycle after the last of their command beats is accepted, and it stays at 1 until reset.
- R7: While `loop_phase` is 1, every beat uses selector 0 with `CMD_BYTE`, and no buffer write happens.
- R8: `xfer_count` goes up by one, modulo 2^`CNT_W`, in the cycle after each accepted command beat, and changes at no other time.
- R9: Command beats are accepted at most once per tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_cmd_q | input | 8 | Current contents of the master's command register (zero = idle) |
| wr_valid | output | 1 | Register write beat offered |
| wr_ready | input | 1 | Master accepts the offered beat |
| wr_addr | output | 2 | Register selector (0 cmd, 1 buf high, 2 buf low, 3 rate) |
| wr_data | output | 8 | Register write data |
| loop_phase | output | 1 | 0 = preload phase, 1 = loopback phase |
| xfer_count | output | CNT_W | Number of command writes accepted since reset |

## Verification
Every beat is judged at the falling edge before the rising edge that takes it, using the same `wr_ready` value the design will sample, and it is compared in order against a queue of expected writes. A command beat taken at edge k moves `xfer_count` and `loop_phase` at that same edge, so both are checked at the next falling edge. The stall rule is checked one falling edge after a refused beat. A transfer start is judged against the idle value that the master model presented one cycle before `wr_valid` rose, because the sequencer decides on a tick and raises `wr_valid` one register later. The master model keeps its command register nonzero for longer than a tick period, so some ticks are dropped and the pacing is actually exercised.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_BUF_HI = 2'd1,
    SEL_BUF_LO = 2'd2,
    SEL_RATE   = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_RATE,
    ST_IDLE,
    ST_HI,
    ST_LO,
    ST_CMD
  } seq_st_e;
endpackage

// File: rtl/spiseq_tick.sv
module spiseq_tick #(
  parameter int PERIOD = 80
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (PERIOD <= 1) begin : g_every
      assign tick = rst_n;
    end else begin : g_count
      localparam int W = $clog2(PERIOD);
      localparam logic [W-1:0] LAST = W'(PERIOD - 1);
      logic [W-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/spiseq_phase.sv
module spiseq_phase #(
  parameter int INIT_XFERS = 255,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_done,
  output logic             loop_phase,
  output logic [CNT_W-1:0] xfer_count
);
  localparam int RW = (INIT_XFERS > 1) ? $clog2(INIT_XFERS + 1) : 1;
  localparam logic [RW-1:0] START = RW'(INIT_XFERS);

  logic [RW-1:0] remaining;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining  <= START;
      xfer_count <= '0;
    end else if (cmd_done) begin
      xfer_count <= xfer_count + 1'b1;
      if (remaining != '0) remaining <= remaining - 1'b1;
    end
  end

  assign loop_phase = (remaining == '0);
endmodule

// File: rtl/spiseq_writer.sv
module spiseq_writer
  import spiseq_pkg::*;
#(
  parameter logic [15:0] DATA_WORD = 16'h0D35,
  parameter logic [7:0]  CMD_BYTE  = 8'hF0,
  parameter logic [7:0]  RATE_BYTE = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] mst_cmd_q,
  input  logic       loop_phase,
  input  logic       wr_ready,
  output logic       wr_valid,
  output logic [1:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       cmd_done
);
  seq_st_e st;
  logic    master_idle;

  assign master_idle = (mst_cmd_q == 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_BOOT;
    else begin
      case (st)
        ST_BOOT: st <= ST_RATE;
        ST_RATE: if (wr_ready) st <= ST_IDLE;
        ST_IDLE: if (tick && master_idle) st <= loop_phase ? ST_CMD : ST_HI;
        ST_HI:   if (wr_ready) st <= ST_LO;
        ST_LO:   if (wr_ready) st <= ST_CMD;
        ST_CMD:  if (wr_ready) st <= ST_IDLE;
        default: st <= ST_BOOT;
      endcase
    end
  end

  always_comb begin
    wr_valid = 1'b1;
    wr_addr  = SEL_CMD;
    wr_data  = CMD_BYTE;
    case (st)
      ST_RATE: begin wr_addr = SEL_RATE;   wr_data = RATE_BYTE;       end
      ST_HI:   begin wr_addr = SEL_BUF_HI; wr_data = DATA_WORD[15:8]; end
      ST_LO:   begin wr_addr = SEL_BUF_LO; wr_data = DATA_WORD[7:0];  end
      ST_CMD:  begin wr_addr = SEL_CMD;    wr_data = CMD_BYTE;        end
      default: begin wr_valid = 1'b0;      wr_data = 8'h00;           end
    endcase
  end

  assign cmd_done = (st == ST_CMD) && wr_ready;
endmodule

// File: rtl/spi_loopback_seq.sv
module spi_loopback_seq #(
  parameter int          TICK_CYCLES = 80,
  parameter int          INIT_XFERS  = 255,
  parameter logic [15:0] DATA_WORD   = 16'h0D35,
  parameter logic [7:0]  CMD_BYTE    = 8'hF0,
  parameter logic [7:0]  RATE_BYTE   = 8'h03,
  parameter int          CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       mst_cmd_q,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [1:0]       wr_addr,
  output logic [7:0]       wr_data,
  output logic             loop_phase,
  output logic [CNT_W-1:0] xfer_count
);
  logic tick;
  logic cmd_done;

  spiseq_tick #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  spiseq_phase #(.INIT_XFERS(INIT_XFERS), .CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done),
    .loop_phase(loop_phase), .xfer_count(xfer_count)
  );

  spiseq_writer #(.DATA_WORD(DATA_WORD), .CMD_BYTE(CMD_BYTE), .RATE_BYTE(RATE_BYTE)) u_writer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mst_cmd_q(mst_cmd_q),
    .loop_phase(loop_phase), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .cmd_done(cmd_done)
  );
endmodule

// File: rtl/spi_loopback_seq_chk.sv
module spi_loopback_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       mst_cmd_q,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [1:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             loop_phase,
  input logic [CNT_W-1:0] xfer_count,
  input logic             tick,
  input logic             cmd_done
);
  // R3: a refused beat is held unchanged
  p_hold_on_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R4: a transfer starts only after a tick that saw an idle master
  p_start_on_idle_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) && wr_addr != 2'd3 |-> $past(tick) && $past(mst_cmd_q) == 8'h00);

  // R6: the loopback phase is never left
  p_phase_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_phase |=> loop_phase);

  // R7: loopback offers command writes only
  p_loop_cmd_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    loop_phase && wr_valid |-> wr_addr == 2'd0);

  // R8: counter steps by one per accepted command beat
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && wr_addr == 2'd0 |=> xfer_count == CNT_W'($past(xfer_count) + 1'b1));

  // R8: counter holds otherwise
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready && wr_addr == 2'd0) |=> $stable(xfer_count));

  // R9: a command beat is accepted once per transfer
  p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
endmodule

bind spi_loopback_seq spi_loopback_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mst_cmd_q(mst_cmd_q), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .loop_phase(loop_phase), .xfer_count(xfer_count), .tick(tick), .cmd_done(cmd_done)
);

// File: tb/spi_loopback_seq_test.sv
module spi_loopback_seq_test;
  localparam int          TICK  = 10;
  localparam int          INIT  = 3;
  localparam int          EXTRA = 4;
  localparam int          BUSY  = 23;
  localparam int          CW    = 8;
  localparam logic [15:0] WORD  = 16'hA5C3;
  localparam logic [7:0]  CMDB  = 8'hF0;
  localparam logic [7:0]  RATEB = 8'h03;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    mst_cmd_q;
  logic          wr_valid, wr_ready, loop_phase;
  logic [1:0]    wr_addr;
  logic [7:0]    wr_data;
  logic [CW-1:0] xfer_count;

  always #5 clk = ~clk;

  spi_loopback_seq #(
    .TICK_CYCLES(TICK), .INIT_XFERS(INIT), .DATA_WORD(WORD),
    .CMD_BYTE(CMDB), .RATE_BYTE(RATEB), .CNT_W(CW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mst_cmd_q(mst_cmd_q), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .loop_phase(loop_phase), .xfer_count(xfer_count)
  );

  int checks = 0;
  int fails  = 0;
  logic [9:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_expected();
    exp_q.push_back({2'd3, RATEB});
    for (int i = 0; i < INIT; i++) begin
      exp_q.push_back({2'd1, WORD[15:8]});
      exp_q.push_back({2'd2, WORD[7:0]});
      exp_q.push_back({2'd0, CMDB});
    end
    for (int i = 0; i < EXTRA; i++) exp_q.push_back({2'd0, CMDB});
  endtask

  bit         started = 0, hold = 0, pend_cnt = 0, stall_pend = 0, prev_valid = 0;
  int         cyc = 0, busy_left = 0, n_cmd = 0, n_beats = 0;
  logic [1:0] st_addr;
  logic [7:0] st_data, prev_cmd = 8'h00, lfsr = 8'h5B;

  // monitor and master model
  always @(negedge clk) begin
    if (started) begin
      cyc++;
      if (pend_cnt) begin
        chk(xfer_count == CW'(n_cmd), "R8 xfer_count", xfer_count, n_cmd);
        chk(loop_phase == (n_cmd >= INIT), "R6 loop_phase", loop_phase, n_cmd >= INIT);
        pend_cnt = 0;
      end
      if (stall_pend) begin
        chk(wr_valid && wr_addr == st_addr && wr_data == st_data, "R3 held beat",
            {wr_valid, wr_addr, wr_data}, {1'b1, st_addr, st_data});
        stall_pend = 0;
      end
      if (wr_valid && !prev_valid && wr_addr != 2'd3)
        chk(prev_cmd == 8'h00, "R4 start with master idle", prev_cmd, 0);
      if (wr_valid && loop_phase)
        chk(wr_addr == 2'd0, "R7 loopback selector", wr_addr, 0);

      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wr_ready = lfsr[0] | lfsr[2];

      if (busy_left > 0) busy_left--;
      if (busy_left == 0 && !hold) mst_cmd_q = 8'h00;

      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 unexpected beat", {wr_addr, wr_data}, 0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({wr_addr, wr_data} == e, (n_beats == 0) ? "R2 rate beat" : "R5 beat order",
              {wr_addr, wr_data}, e);
        end
        n_beats++;
        if (wr_addr == 2'd0) begin
          n_cmd++;
          pend_cnt  = 1;
          chk(n_cmd * TICK <= cyc + TICK, "R9 command pacing", n_cmd * TICK, cyc + TICK);
          mst_cmd_q = wr_data;
          busy_left = BUSY;
          if (n_cmd == INIT + EXTRA) hold = 1;
        end
      end else if (wr_valid) begin
        stall_pend = 1;
        st_addr    = wr_addr;
        st_data    = wr_data;
      end
      prev_valid = wr_valid;
      prev_cmd   = mst_cmd_q;
    end
  end

  initial begin
    rst_n     = 1'b0;
    mst_cmd_q = 8'h00;
    wr_ready  = 1'b0;
    push_expected();
    repeat (3) @(negedge clk);
    chk(wr_valid == 1'b0, "R1 valid in reset", wr_valid, 0);
    chk(loop_phase == 1'b0, "R1 phase in reset", loop_phase, 0);
    chk(xfer_count == '0, "R1 count in reset", xfer_count, 0);
    rst_n   = 1'b1;
    started = 1;
    begin : wait_done
      for (int i = 0; i < 20000; i++) begin
        @(negedge clk);
        if (hold) disable wait_done;
      end
    end
    if (!hold) chk(1'b0, "R6 watchdog expired", n_cmd, INIT + EXTRA);
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all expected beats seen", exp_q.size(), 0);
    chk(loop_phase == 1'b1, "R6 phase after run", loop_phase, 1);
    chk(wr_valid == 1'b0, "R4 no start while master busy", wr_valid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule